// File: doc/BRIEF.md
# Subcarrier Manchester response encoder

This block turns the bytes of a tag's response frame into the on/off control for load modulation. It runs on the carrier clock. Each bit time is split into two halves. A half is either silent or a burst of subcarrier pulses, and the subcarrier is the carrier clock divided by a fixed ratio. With the default settings the ratio is 32, each burst holds 8 pulses, a half lasts 256 carrier clocks and a bit lasts 512 carrier clocks, which is about 26.48 kbit/s on a 13.56 MHz carrier. Only this single-subcarrier, fast-rate format is produced.

Upstream logic supplies the response bytes, CRC included, over a valid/ready handshake. A first marker opens a frame and a last marker closes it. The encoder puts a start delimiter in front of the data and an end delimiter after it. Both delimiters break the normal Manchester rule on purpose, so a reader can tell them apart from data. A one-byte look-ahead register lets the upstream logic hand over the next byte at any time while the current byte is on the air. A busy flag is high from the first half of the start delimiter through the last half of the end delimiter.

Top module: `subcarrier_manchester_enc`

## Requirements
- R1: During a burst half, `modOut` repeats a subcarrier period of DIV clocks: high for the first DIV/2 clocks and low for the rest. A burst half holds PULSES periods, so every half, burst or silent, lasts H = DIV*PULSES clocks, and each burst starts with its high phase.
- R2: After reset and while idle, `modOut` and `busy` are low and `inReady` is high.
- R3: A frame starts on the clock edge that accepts a byte (`inValid` and `inReady` both high) with `inFirst` high while the block is idle. Frame time 0 is the cycle after that edge, and `busy` is high from frame time 0 onward.
- R4: The start delimiter is 8 halves, in time order: silent, silent, silent, burst, burst, burst, silent, burst.
- R5: A data bit of 0 is a burst half followed by a silent half. A data bit of 1 is a silent half followed by a burst half.
- R6: Data bits go out least significant bit first. Bytes go out in the order they were accepted, with no gap between them.
- R7: The end delimiter follows the last data bit and is 8 halves, in time order: burst, silent, burst, burst, burst, silent, silent, silent. `busy` falls, and `modOut` stays low, from frame time (16 + 16*N)*H on, where N is the number of data bytes.
- R8: A byte accepted while idle with `inFirst` low is discarded. It starts no frame, and `modOut` and `busy` stay low.
- R9: Once the byte carrying `inLast` has been accepted, `inReady` stays low until the frame ends.
- R10: If no byte is waiting when a data byte finishes, the end delimiter follows at once, even when no byte carried `inLast`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Upstream byte is valid |
| inReady | output | 1 | Encoder can take a byte this cycle |
| inData | input | BYTE_W | Response byte |
| inFirst | input | 1 | Byte opens a frame |
| inLast | input | 1 | Byte closes a frame |
| busy | output | 1 | Frame in progress |
| modOut | output | 1 | Load-modulation control, high means load on |

## Verification
A bad internal state in the half-bit sequencer appears on `modOut` within one half-bit, H clocks. It shows as a burst that comes in the wrong place, or one that is missing or extra, because every half is either fully silent or fully pulsed. A wrong subcarrier phase appears within one subcarrier period as a pulse that is shifted or the wrong width. A byte that is lost, repeated or bit-reversed appears within one bit time of the place where it should go out. A wrong end of frame shows on `busy` and on `inReady` in the exact cycle the frame should close. The bench therefore predicts `modOut` and `busy` for every cycle of every frame, so any one of these faults shows as a difference in the cycle where it first occurs.

// File: rtl/sme_pkg.sv
package sme_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SOF  = 2'd1,
    PH_DATA = 2'd2,
    PH_EOF  = 2'd3
  } phase_t;

  // Delimiter shapes, one bit per half-bit, index 0 sent first, 1 = burst.
  localparam logic [7:0] SOF_SHAPE = 8'b1011_1000;
  localparam logic [7:0] EOF_SHAPE = 8'b0001_1101;

  // Control to datapath strobes.
  typedef struct packed {
    logic capFirst;  // take opening byte into shift register
    logic capNext;   // take byte into look-ahead slot
    logic loadNext;  // move look-ahead byte into shift register
    logic shiftBit;  // advance to next data bit
    logic run;       // frame in progress, subcarrier runs
    logic burst;     // current half-bit is a pulse burst
  } strobes_t;

  // Datapath to control status.
  typedef struct packed {
    logic scTick;    // last clock of a subcarrier period
    logic curBit;    // data bit now on air
    logic pendFull;  // look-ahead slot holds a byte
    logic lastSeen;  // closing byte has been accepted
  } status_t;

endpackage

// File: rtl/sme_ctrl.sv
module sme_ctrl
  import sme_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PULSES = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inFirst,
  input  status_t  st,
  output logic     inReady,
  output logic     busy,
  output strobes_t sb
);

  localparam int HW = $clog2(2 * BYTE_W);
  localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [HW-1:0] DATA_LAST = HW'(2 * BYTE_W - 1);
  localparam logic [HW-1:0] DLM_LAST  = HW'(7);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSES - 1);

  phase_t        phase;
  logic [HW-1:0] halfIdx;
  logic [PW-1:0] pulseCnt;
  logic          halfEnd;
  logic          segEnd;
  logic          accept;
  logic          burstNow;

  always_comb begin
    halfEnd = st.scTick && (pulseCnt == PULSE_LAST);
    segEnd  = (phase == PH_DATA) ? (halfIdx == DATA_LAST) : (halfIdx == DLM_LAST);
    case (phase)
      PH_IDLE: inReady = 1'b1;
      PH_SOF:  inReady = !st.pendFull && !st.lastSeen;
      PH_DATA: inReady = !st.pendFull && !st.lastSeen && !(halfEnd && segEnd);
      default: inReady = 1'b0;
    endcase
    accept = inValid && inReady;
    case (phase)
      PH_SOF:  burstNow = SOF_SHAPE[halfIdx[2:0]];
      PH_DATA: burstNow = halfIdx[0] ? st.curBit : !st.curBit;
      PH_EOF:  burstNow = EOF_SHAPE[halfIdx[2:0]];
      default: burstNow = 1'b0;
    endcase
  end

  always_comb begin
    sb.capFirst = (phase == PH_IDLE) && accept && inFirst;
    sb.capNext  = ((phase == PH_SOF) || (phase == PH_DATA)) && accept;
    sb.loadNext = (phase == PH_DATA) && halfEnd && segEnd && st.pendFull;
    sb.shiftBit = (phase == PH_DATA) && halfEnd && halfIdx[0] && !segEnd;
    sb.run      = (phase != PH_IDLE);
    sb.burst    = burstNow;
    busy        = (phase != PH_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      halfIdx  <= '0;
      pulseCnt <= '0;
    end else if (phase == PH_IDLE) begin
      halfIdx  <= '0;
      pulseCnt <= '0;
      if (sb.capFirst) phase <= PH_SOF;
    end else if (st.scTick) begin
      if (!halfEnd) begin
        pulseCnt <= pulseCnt + 1'b1;
      end else begin
        pulseCnt <= '0;
        if (!segEnd) begin
          halfIdx <= halfIdx + 1'b1;
        end else begin
          halfIdx <= '0;
          case (phase)
            PH_SOF:  phase <= PH_DATA;
            PH_DATA: phase <= st.pendFull ? PH_DATA : PH_EOF;
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  // R3: a frame only begins after an accepted opening byte.
  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(sb.capFirst));

  // R9: no byte is taken after the closing one while the frame runs.
  assert_ready_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && st.lastSeen) |-> !inReady);

  // R1: half-bit position moves only on subcarrier period boundaries.
  assert_half_steps_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !st.scTick) |=> $stable(halfIdx));

endmodule

// File: rtl/sme_datapath.sv
module sme_datapath
  import sme_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  input  strobes_t          sb,
  output status_t           st,
  output logic              modOut
);

  localparam int SW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [SW-1:0] SC_LAST = SW'(DIV - 1);
  localparam logic [SW-1:0] SC_HALF = SW'(DIV / 2);

  logic [SW-1:0]     scCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] pendReg;
  logic              pendFull;
  logic              lastSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scCnt <= '0;
    end else if (sb.capFirst) begin
      scCnt <= '0;
    end else if (sb.run) begin
      scCnt <= (scCnt == SC_LAST) ? '0 : scCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      pendReg  <= '0;
      pendFull <= 1'b0;
      lastSeen <= 1'b0;
    end else begin
      if (sb.capFirst) begin
        shiftReg <= inData;
        pendFull <= 1'b0;
        lastSeen <= inLast;
      end else begin
        if (sb.loadNext) begin
          shiftReg <= pendReg;
          pendFull <= 1'b0;
        end else if (sb.shiftBit) begin
          shiftReg <= shiftReg >> 1;
        end
        if (sb.capNext) begin
          pendReg  <= inData;
          pendFull <= 1'b1;
          if (inLast) lastSeen <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    st.scTick   = sb.run && (scCnt == SC_LAST);
    st.curBit   = shiftReg[0];
    st.pendFull = pendFull;
    st.lastSeen = lastSeen;
    modOut      = sb.burst && (scCnt < SC_HALF);
  end

  // R2: nothing is modulated outside a frame.
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sb.run |-> !modOut);

  // R1: every pulse begins at the start of a subcarrier period.
  assert_pulse_align_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modOut) |-> (scCnt == '0));

  // R6: a waiting byte is never overwritten.
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rstN)
    sb.capNext |-> !pendFull);

endmodule

// File: rtl/subcarrier_manchester_enc.sv
module subcarrier_manchester_enc
  import sme_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV    = 32,
  parameter int PULSES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inFirst,
  input  logic              inLast,
  output logic              busy,
  output logic              modOut
);

  strobes_t sb;
  status_t  st;

  sme_ctrl #(
    .BYTE_W(BYTE_W),
    .PULSES(PULSES)
  ) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inFirst(inFirst),
    .st     (st),
    .inReady(inReady),
    .busy   (busy),
    .sb     (sb)
  );

  sme_datapath #(
    .BYTE_W(BYTE_W),
    .DIV   (DIV)
  ) dp (
    .clk   (clk),
    .rstN  (rstN),
    .inData(inData),
    .inLast(inLast),
    .sb    (sb),
    .st    (st),
    .modOut(modOut)
  );

endmodule

// File: tb/subcarrier_manchester_enc_test.sv
`timescale 1ns/1ps
module subcarrier_manchester_enc_test;

  localparam int DIV    = 4;
  localparam int PULSES = 2;
  localparam int H      = DIV * PULSES;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inData = 8'h00;
  logic       inFirst = 1'b0;
  logic       inLast = 1'b0;
  logic       busy;
  logic       modOut;

  int checks = 0;
  int errors = 0;
  int failPrints = 0;
  bit startFlag = 1'b0;
  bit done = 1'b0;
  logic [7:0] fb [0:7];

  subcarrier_manchester_enc #(.BYTE_W(8), .DIV(DIV), .PULSES(PULSES)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inFirst(inFirst), .inLast(inLast),
    .busy(busy), .modOut(modOut)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (failPrints < 20) begin
        failPrints++;
        $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Burst flag of half n of a frame with nb data bytes (R4, R5, R6, R7).
  function automatic bit expBurst(input int n, input int nb);
    bit [7:0] sofShape = 8'b1011_1000;
    bit [7:0] eofShape = 8'b0001_1101;
    int m;
    bit b;
    if (n < 8) return sofShape[n];
    m = n - 8;
    if (m < 16 * nb) begin
      b = fb[m / 16][(m % 16) / 2];
      return (m % 2 == 1) ? b : !b;
    end
    return eofShape[m - 16 * nb];
  endfunction

  function automatic string tagOf(input int n, input int nb);
    if (n < 8) return "R4";
    if (n < 8 + 16 * nb) return "R5/R6";
    return "R7";
  endfunction

  task automatic pushByte(input logic [7:0] d, input bit f, input bit l);
    @(negedge clk);
    inValid = 1'b1; inData = d; inFirst = f; inLast = l;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    if (f) startFlag = 1'b1;
    #1;
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
  endtask

  task automatic watchFrame(input int nb, input bit readyLow);
    int total;
    bit eb;
    int expMod;
    wait (startFlag);
    startFlag = 1'b0;
    total = (16 + 16 * nb) * H;
    for (int t = 0; t < total + 4; t++) begin
      @(negedge clk);
      if (t < total) begin
        eb = expBurst(t / H, nb);
        expMod = (eb && ((t % DIV) < DIV / 2)) ? 1 : 0;
        check(modOut == expMod[0], {tagOf(t / H, nb), " R1 modOut"}, int'(modOut), expMod);
        check(busy == 1'b1, "R3 busy in frame", int'(busy), 1);
        if (readyLow) check(inReady == 1'b0, "R9 ready after last", int'(inReady), 0);
      end else begin
        check(modOut == 1'b0, "R7 modOut after frame", int'(modOut), 0);
        check(busy == 1'b0, "R7 busy after frame", int'(busy), 0);
        check(inReady == 1'b1, "R2 ready when idle", int'(inReady), 1);
      end
    end
  endtask

  task automatic runFrame(input int nb, input bit withLast, input int gap);
    fork
      begin
        for (int i = 0; i < nb; i++) begin
          pushByte(fb[i], i == 0, withLast && (i == nb - 1));
          repeat (gap) @(negedge clk);
        end
      end
      watchFrame(nb, withLast && nb == 1);
    join
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=timeout expected=frame_end");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check(modOut == 1'b0, "R2 modOut in reset", int'(modOut), 0);
    check(busy == 1'b0, "R2 busy in reset", int'(busy), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(modOut == 1'b0, "R2 modOut idle", int'(modOut), 0);
    check(busy == 1'b0, "R2 busy idle", int'(busy), 0);
    check(inReady == 1'b1, "R2 ready idle", int'(inReady), 1);

    // R8: a byte without the opening marker is dropped
    pushByte(8'hA5, 1'b0, 1'b1);
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      check(modOut == 1'b0, "R8 modOut stays low", int'(modOut), 0);
      check(busy == 1'b0, "R8 busy stays low", int'(busy), 0);
    end

    // R4 R5 R6 R7 R9: every byte value as a one-byte closed frame
    for (int v = 0; v < 256; v++) begin
      fb[0] = v[7:0];
      runFrame(1, 1'b1, 0);
    end

    // R6: multi-byte frames, back to back and with upstream gaps
    fb[0] = 8'h01; fb[1] = 8'h80; fb[2] = 8'h3C;
    runFrame(3, 1'b1, 0);
    fb[0] = 8'hF0; fb[1] = 8'h0F; fb[2] = 8'h55; fb[3] = 8'hAA;
    runFrame(4, 1'b1, 30);
    fb[0] = 8'hC3; fb[1] = 8'h96;
    runFrame(2, 1'b1, 90);

    // R10: no closing marker, frame ends when bytes run out
    fb[0] = 8'h6B;
    runFrame(1, 1'b0, 0);
    fb[0] = 8'h12; fb[1] = 8'hED;
    runFrame(2, 1'b0, 5);

    // R8: dropped byte after frames, idle must stay quiet
    pushByte(8'hFF, 1'b0, 1'b0);
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      check(modOut == 1'b0, "R8 modOut quiet", int'(modOut), 0);
      check(busy == 1'b0, "R8 busy quiet", int'(busy), 0);
    end

    done = 1'b1;
    finishRun();
  end

endmodule